// File: doc/BRIEF.md
# Receiver Lock Qualifier and Auto-Mute Gate

This block sits between a digital-audio receiver front end and the sample path that feeds the interpolator. It takes four raw status signals from the receiver: clock-recovery lock, biphase-decoder lock, the channel-status flag that marks a stream as non-audio, and a burst-preamble detector. These signals come from other timing domains. The block resynchronises them, qualifies them, and drives two status pins. One is a lock indicator that normally requires real PCM audio. The other is a PCM-detect indicator. It also exposes the individual lock and PCM bits as read-only status for a register file.

On the sample path, each stereo sample pair arrives with a one-cycle strobe. The block registers the pair and replaces it with zeros whenever the input is not fully locked. This hard mute acts on the very next strobe and has no ramp. A bypass control lets samples through even when the input is out of lock. A second control makes the lock indicator show lock status alone, without the PCM qualification.

Top module: `audio_lock_gate`

## Requirements
- R1: `pcm_det_out` is 1 exactly when the synchronised non-audio flag (`nonpcm_in`, 1 = non-PCM) is 0 and the synchronised burst detector (`burst_in`) is 0. `st_pcm_valid` is 1 exactly when the synchronised `nonpcm_in` is 0, whatever the value of `burst_in`.
- R2: With `cfg_lock_only` = 0, `lock_out` is 1 exactly when the synchronised `pll_lock_in`, the synchronised `dec_lock_in` and `pcm_det_out` are all 1.
- R3: With `cfg_lock_only` = 0, when both locks are present but `nonpcm_in` = 1 or `burst_in` = 1, `lock_out` is 0.
- R4: With `cfg_lock_only` = 1, `lock_out` equals the AND of the synchronised locks, independent of `nonpcm_in` and `burst_in`.
- R5: A strobe (`smp_valid_in` = 1) taken while either registered lock status is 0 and `cfg_mute_bypass` = 0 yields zero on both `smp_left_out` and `smp_right_out`. `smp_valid_out` still pulses.
- R6: With `cfg_mute_bypass` = 1, strobed samples pass through unchanged even when both locks are absent.
- R7: A strobe taken while both locks are present appears on the sample outputs, unchanged, with `smp_valid_out` = 1 one clock after the strobe.
- R8: A change on any status input reaches `lock_out`, `pcm_det_out` and the `st_*` outputs after exactly three rising clock edges: two synchroniser stages and one output register.
- R9: While `rst_n` is 0, every output is 0.
- R10: The loss of only one lock (PLL alone or decoder alone) mutes every strobe taken once that loss has reached the status registers.
- R11: Between strobes, `smp_left_out` and `smp_right_out` hold their last values, and `smp_valid_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_lock_in | input | 1 | Clock-recovery lock, asynchronous |
| dec_lock_in | input | 1 | Biphase decoder lock, asynchronous |
| nonpcm_in | input | 1 | Channel-status flag, 1 = non-audio data, asynchronous |
| burst_in | input | 1 | Burst preamble seen, asynchronous |
| cfg_mute_bypass | input | 1 | 1 = pass samples even when out of lock |
| cfg_lock_only | input | 1 | 1 = lock indicator ignores PCM qualification |
| smp_valid_in | input | 1 | One-cycle sample strobe |
| smp_left_in | input | SAMPLE_W | Left sample |
| smp_right_in | input | SAMPLE_W | Right sample |
| lock_out | output | 1 | Qualified lock indicator |
| pcm_det_out | output | 1 | PCM audio detected |
| smp_valid_out | output | 1 | Output sample strobe |
| smp_left_out | output | SAMPLE_W | Gated left sample |
| smp_right_out | output | SAMPLE_W | Gated right sample |
| st_pll_lock | output | 1 | Read-only status: PLL locked |
| st_dec_lock | output | 1 | Read-only status: decoder locked |
| st_pcm_valid | output | 1 | Read-only status: channel status marks PCM |

## Verification
The properties assume that `cfg_mute_bypass` and `cfg_lock_only` are quasi-static, and that each strobe is judged against the control value from the cycle it was taken. The bench changes these controls only on falling edges, well ahead of the strobes that depend on them. The properties also assume that a status input holds for longer than the synchroniser depth. The bench waits at least four cycles after every status change before it strobes or compares, except in the latency scenario, which samples on each edge on purpose.

// File: rtl/audio_lock_pkg.sv
package audio_lock_pkg;

    typedef struct packed {
        logic pll;
        logic dec;
        logic nonpcm;
        logic burst;
    } rx_stat_t;

    localparam int unsigned RX_STAT_W = $bits(rx_stat_t);

    typedef struct packed {
        logic lock;
        logic pcm_det;
        logic pll;
        logic dec;
        logic pcm_ok;
    } lock_state_t;

endpackage

// File: rtl/status_sync.sv
module status_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/lock_combine.sv
module lock_combine
    import audio_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  rx_stat_t    stat_s,
    input  logic        cfg_lock_only,
    output lock_state_t state_q
);
    lock_state_t state_d;

    always_comb begin
        logic both_locked;
        logic audio_ok;
        both_locked      = stat_s.pll & stat_s.dec;
        audio_ok         = ~stat_s.nonpcm & ~stat_s.burst;
        state_d.pll      = stat_s.pll;
        state_d.dec      = stat_s.dec;
        state_d.pcm_ok   = ~stat_s.nonpcm;
        state_d.pcm_det  = audio_ok;
        state_d.lock     = cfg_lock_only ? both_locked : (both_locked & audio_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/mute_gate.sv
module mute_gate #(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pass_en,
    input  logic                valid_in,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                valid_out,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out
);
    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d       = gate_q;
        gate_d.valid = valid_in;
        if (valid_in) begin
            gate_d.left  = pass_en ? left_in  : '0;
            gate_d.right = pass_en ? right_in : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign valid_out = gate_q.valid;
    assign left_out  = gate_q.left;
    assign right_out = gate_q.right;
endmodule

// File: rtl/audio_lock_gate.sv
module audio_lock_gate
    import audio_lock_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pll_lock_in,
    input  logic                dec_lock_in,
    input  logic                nonpcm_in,
    input  logic                burst_in,
    input  logic                cfg_mute_bypass,
    input  logic                cfg_lock_only,
    input  logic                smp_valid_in,
    input  logic [SAMPLE_W-1:0] smp_left_in,
    input  logic [SAMPLE_W-1:0] smp_right_in,
    output logic                lock_out,
    output logic                pcm_det_out,
    output logic                smp_valid_out,
    output logic [SAMPLE_W-1:0] smp_left_out,
    output logic [SAMPLE_W-1:0] smp_right_out,
    output logic                st_pll_lock,
    output logic                st_dec_lock,
    output logic                st_pcm_valid
);
    rx_stat_t    stat_raw;
    rx_stat_t    stat_s;
    lock_state_t state_q;
    logic        pass_en;

    always_comb begin
        stat_raw.pll    = pll_lock_in;
        stat_raw.dec    = dec_lock_in;
        stat_raw.nonpcm = nonpcm_in;
        stat_raw.burst  = burst_in;
    end

    status_sync #(
        .WIDTH  (RX_STAT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stat_raw),
        .sync_out (stat_s)
    );

    lock_combine u_comb (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_s        (stat_s),
        .cfg_lock_only (cfg_lock_only),
        .state_q       (state_q)
    );

    // Hard mute: a strobe passes only with both locks registered or bypass set.
    assign pass_en = (state_q.pll & state_q.dec) | cfg_mute_bypass;

    mute_gate #(
        .SAMPLE_W (SAMPLE_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_en   (pass_en),
        .valid_in  (smp_valid_in),
        .left_in   (smp_left_in),
        .right_in  (smp_right_in),
        .valid_out (smp_valid_out),
        .left_out  (smp_left_out),
        .right_out (smp_right_out)
    );

    assign lock_out     = state_q.lock;
    assign pcm_det_out  = state_q.pcm_det;
    assign st_pll_lock  = state_q.pll;
    assign st_dec_lock  = state_q.dec;
    assign st_pcm_valid = state_q.pcm_ok;
endmodule

// File: rtl/audio_lock_gate_chk.sv
module audio_lock_gate_chk #(
    parameter int unsigned SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_mute_bypass,
    input logic                cfg_lock_only,
    input logic                smp_valid_in,
    input logic [SAMPLE_W-1:0] smp_left_in,
    input logic [SAMPLE_W-1:0] smp_right_in,
    input logic                lock_out,
    input logic                pcm_det_out,
    input logic                smp_valid_out,
    input logic [SAMPLE_W-1:0] smp_left_out,
    input logic [SAMPLE_W-1:0] smp_right_out,
    input logic                st_pll_lock,
    input logic                st_dec_lock,
    input logic                st_pcm_valid
);
    assert_pcm_needs_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_det_out |-> st_pcm_valid);

    assert_lock_needs_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_out && !$past(cfg_lock_only)) |-> (st_pll_lock && st_dec_lock && pcm_det_out));

    assert_nonpcm_drops_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pcm_det_out && !$past(cfg_lock_only)) |-> !lock_out);

    assert_lock_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_lock_only) |-> (lock_out == (st_pll_lock && st_dec_lock)));

    assert_auto_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_in && !cfg_mute_bypass && !(st_pll_lock && st_dec_lock))
        |=> (smp_left_out == '0 && smp_right_out == '0));

    assert_bypass_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_in && cfg_mute_bypass)
        |=> (smp_left_out == $past(smp_left_in) && smp_right_out == $past(smp_right_in)));

    assert_locked_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_in && st_pll_lock && st_dec_lock)
        |=> (smp_valid_out && smp_left_out == $past(smp_left_in)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_in |=> (!smp_valid_out && $stable(smp_left_out) && $stable(smp_right_out)));
endmodule

bind audio_lock_gate audio_lock_gate_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_mute_bypass (cfg_mute_bypass),
    .cfg_lock_only   (cfg_lock_only),
    .smp_valid_in    (smp_valid_in),
    .smp_left_in     (smp_left_in),
    .smp_right_in    (smp_right_in),
    .lock_out        (lock_out),
    .pcm_det_out     (pcm_det_out),
    .smp_valid_out   (smp_valid_out),
    .smp_left_out    (smp_left_out),
    .smp_right_out   (smp_right_out),
    .st_pll_lock     (st_pll_lock),
    .st_dec_lock     (st_dec_lock),
    .st_pcm_valid    (st_pcm_valid)
);

// File: tb/audio_lock_gate_tb.sv
`timescale 1ns/1ps
module audio_lock_gate_tb;
    localparam int unsigned SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_lock_in = 1'b0, dec_lock_in = 1'b0, nonpcm_in = 1'b0, burst_in = 1'b0;
    logic          cfg_mute_bypass = 1'b0, cfg_lock_only = 1'b0;
    logic          smp_valid_in = 1'b0;
    logic [SW-1:0] smp_left_in = '0, smp_right_in = '0;
    logic          lock_out, pcm_det_out, smp_valid_out;
    logic [SW-1:0] smp_left_out, smp_right_out;
    logic          st_pll_lock, st_dec_lock, st_pcm_valid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    audio_lock_gate #(.SAMPLE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pll_lock_in(pll_lock_in), .dec_lock_in(dec_lock_in),
        .nonpcm_in(nonpcm_in), .burst_in(burst_in),
        .cfg_mute_bypass(cfg_mute_bypass), .cfg_lock_only(cfg_lock_only),
        .smp_valid_in(smp_valid_in), .smp_left_in(smp_left_in), .smp_right_in(smp_right_in),
        .lock_out(lock_out), .pcm_det_out(pcm_det_out), .smp_valid_out(smp_valid_out),
        .smp_left_out(smp_left_out), .smp_right_out(smp_right_out),
        .st_pll_lock(st_pll_lock), .st_dec_lock(st_dec_lock), .st_pcm_valid(st_pcm_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_stat(input logic p, input logic d, input logic np, input logic b);
        @(negedge clk);
        pll_lock_in = p; dec_lock_in = d; nonpcm_in = np; burst_in = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(negedge clk);
        smp_valid_in = 1'b1; smp_left_in = l; smp_right_in = r;
        @(negedge clk);
        smp_valid_in = 1'b0; smp_left_in = ~l; smp_right_in = ~r;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        pll_lock_in = 1'b1; dec_lock_in = 1'b1; smp_valid_in = 1'b1; smp_left_in = 24'h123456;
        repeat (5) @(negedge clk);
        check("R9 lock_out", lock_out, 0);
        check("R9 pcm_det_out", pcm_det_out, 0);
        check("R9 valid", smp_valid_out, 0);
        check("R9 left", smp_left_out, 0);
        check("R9 status", {st_pll_lock, st_dec_lock, st_pcm_valid}, 0);
        pll_lock_in = 1'b0; dec_lock_in = 1'b0; smp_valid_in = 1'b0; smp_left_in = '0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_latency;
        @(negedge clk);
        pll_lock_in = 1'b1; dec_lock_in = 1'b1; nonpcm_in = 1'b0; burst_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 lock after two edges", lock_out, 0);
        check("R8 pll status after two edges", st_pll_lock, 0);
        @(negedge clk);
        check("R8 lock after three edges", lock_out, 1);
        check("R8 status after three edges", {st_pll_lock, st_dec_lock, st_pcm_valid}, 3'b111);
    endtask

    task automatic t_locked_pcm;
        set_stat(1, 1, 0, 0);
        check("R2 lock with pcm", lock_out, 1);
        check("R1 pcm_det with pcm", pcm_det_out, 1);
        strobe(24'hA5A5A5, 24'h5A5A5A);
        check("R7 valid out", smp_valid_out, 1);
        check("R7 left pass", smp_left_out, 24'hA5A5A5);
        check("R7 right pass", smp_right_out, 24'h5A5A5A);
        @(negedge clk);
        check("R11 valid low", smp_valid_out, 0);
        check("R11 left hold", smp_left_out, 24'hA5A5A5);
        check("R11 right hold", smp_right_out, 24'h5A5A5A);
    endtask

    task automatic t_nonpcm;
        set_stat(1, 1, 1, 0);
        check("R3 lock low nonpcm", lock_out, 0);
        check("R1 pcm_det low nonpcm", pcm_det_out, 0);
        check("R1 st_pcm_valid low nonpcm", st_pcm_valid, 0);
        strobe(24'h000111, 24'h000222);
        check("R7 nonpcm locked still passes", smp_left_out, 24'h000111);
        set_stat(1, 1, 0, 1);
        check("R3 lock low burst", lock_out, 0);
        check("R1 pcm_det low burst", pcm_det_out, 0);
        check("R1 st_pcm_valid ignores burst", st_pcm_valid, 1);
    endtask

    task automatic t_lock_only;
        @(negedge clk); cfg_lock_only = 1'b1;
        set_stat(1, 1, 1, 1);
        check("R4 lock only ignores pcm", lock_out, 1);
        check("R4 pcm_det still low", pcm_det_out, 0);
        set_stat(1, 0, 0, 0);
        check("R4 lock only needs decoder", lock_out, 0);
        @(negedge clk); cfg_lock_only = 1'b0;
    endtask

    task automatic t_automute;
        set_stat(0, 0, 0, 0);
        check("R2 lock low unlocked", lock_out, 0);
        strobe(24'h7FFFFF, 24'h800001);
        check("R5 valid still pulses", smp_valid_out, 1);
        check("R5 left zero", smp_left_out, 0);
        check("R5 right zero", smp_right_out, 0);
    endtask

    task automatic t_single_loss;
        set_stat(1, 1, 0, 0);
        strobe(24'h111111, 24'h222222);
        check("R10 pre-loss pass", smp_left_out, 24'h111111);
        set_stat(0, 1, 0, 0);
        strobe(24'h333333, 24'h444444);
        check("R10 pll loss mutes", {smp_left_out, smp_right_out}, 0);
        set_stat(1, 0, 0, 0);
        strobe(24'h555555, 24'h666666);
        check("R10 decoder loss mutes", {smp_left_out, smp_right_out}, 0);
    endtask

    task automatic t_bypass;
        set_stat(0, 0, 0, 0);
        @(negedge clk); cfg_mute_bypass = 1'b1;
        strobe(24'hC0FFEE, 24'h0BADF0);
        check("R6 bypass left", smp_left_out, 24'hC0FFEE);
        check("R6 bypass right", smp_right_out, 24'h0BADF0);
        check("R6 lock still low", lock_out, 0);
        @(negedge clk); cfg_mute_bypass = 1'b0;
        strobe(24'h010203, 24'h040506);
        check("R5 mute after bypass cleared", smp_left_out, 0);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_latency();
        t_locked_pcm();
        t_nonpcm();
        t_lock_only();
        t_automute();
        t_single_loss();
        t_bypass();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule